// File: doc/BRIEF.md
# Virtual Interrupt Acknowledge Unit

This block is the acknowledge path of a virtual CPU interface. It keeps a small table of list entries. Each entry holds an interrupt ID, a source CPU number, an 8-bit priority, a group bit and a state. A read of the aliased acknowledge offset does two things at once. It returns an interrupt ID, and it can acknowledge the interrupt that this ID names. The block picks the pending entry with the highest priority. It acknowledges that entry only if the entry is in Group 1, passes the priority mask, and is more urgent than every interrupt already active.

When an entry is acknowledged, it moves from pending to active, and the matching bit of a 32-bit active-priority register is set. In every other case the read returns the spurious ID 1023 and nothing changes. A global enable, a priority mask and two software ports complete the block. One port loads list entries. The other loads and exposes the active-priority register.

Top module: `virq_ack_unit`

## Requirements
- R1: After reset, respValid is 0, aprOut is 0 and every entry state in lrStateOut is invalid. The state codes are 00 for invalid, 01 for pending and 10 for active. Entry i occupies lrStateOut[2i+1:2i].
- R2: A read (reqValid=1, reqWrite=0) at reqAddr 0x020 gives respValid=1 on the next cycle. In that response, respData[31:13] is zero and the ID is in bits [9:0]. For IDs below 16, bits [12:10] carry the entry's source CPU; for other IDs those bits are zero.
- R3: Suppose the winning entry is Group 1 and qualifies. The read then returns the entry's ID, the entry becomes active and aprOut bit priority[7:3] is set. All three changes appear in the same cycle as the response.
- R4: If the highest-priority pending entry is Group 0, the read returns 1023 and no entry state or aprOut bit changes. This holds even when a lower-priority Group 1 entry is pending.
- R5: An entry qualifies only if its priority is strictly lower in value than prioMask. Otherwise the read returns 1023 with no change.
- R6: An entry qualifies only if priority[7:3] is strictly below the index of the lowest set bit of aprOut. When aprOut is zero, this condition always holds.
- R7: While ctlEnable is 0, every read returns 1023 and changes nothing.
- R8: With no pending entry, a read returns 1023.
- R9: Among pending entries of equal priority, the one with the lower index wins.
- R10: A write to 0x020 is ignored: it gives no response and changes no state. A read at any other offset gives no response.
- R11: lrWrEn loads the entry at lrWrIdx, and aprWrEn loads aprOut. Either write takes precedence over an acknowledge update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Bus request strobe |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 12 | Request byte offset |
| respValid | output | 1 | Read response valid |
| respData | output | 32 | Read response data |
| ctlEnable | input | 1 | Interrupt signalling enable |
| prioMask | input | 8 | Priority mask threshold |
| lrWrEn | input | 1 | List entry load strobe |
| lrWrIdx | input | 2 | Entry index to load |
| lrWrId | input | 10 | Interrupt ID to load |
| lrWrSrc | input | 3 | Source CPU to load |
| lrWrPrio | input | 8 | Priority to load |
| lrWrGroup | input | 1 | Group to load (1 = Group 1) |
| lrWrState | input | 2 | State to load |
| lrStateOut | output | 8 | Packed entry states |
| aprWrEn | input | 1 | Active-priority load strobe |
| aprWrData | input | 32 | Active-priority load value |
| aprOut | output | 32 | Active-priority register |

## Verification
The assertions rely on three conditions on the inputs:
- No list entry is loaded with an ID in the range 1020 to 1023. A real acknowledge can therefore always be told apart from the spurious value.
- Software loads are never issued in the same cycle as an acknowledge read.
- lrWrState only carries one of the three defined codes.

The stimulus keeps within these conditions. Every entry and active-priority load is its own bus-quiet cycle, performed before the read. All IDs are chosen well below 1020.

// File: rtl/virq_ack_pkg.sv
package virq_ack_pkg;
  localparam logic [1:0] LR_INVALID = 2'b00;
  localparam logic [1:0] LR_PENDING = 2'b01;
  localparam logic [1:0] LR_ACTIVE  = 2'b10;
  localparam int SPURIOUS_ID = 1023;

  typedef struct packed {
    logic respLoad;
    logic ackFire;
  } ackStrobe_t;
endpackage

// File: rtl/virq_ack_datapath.sv
module virq_ack_datapath
  import virq_ack_pkg::*;
#(
  parameter int NUM_LR    = 4,
  parameter int ID_W      = 10,
  parameter int SRC_W     = 3,
  parameter int PRIO_W    = 8,
  parameter int APR_W     = 32,
  parameter int DATA_W    = 32,
  parameter int SGI_LIMIT = 16,
  localparam int IDX_W    = (NUM_LR > 1) ? $clog2(NUM_LR) : 1,
  localparam int APR_IDX_W = $clog2(APR_W),
  localparam int PRIO_SHIFT = PRIO_W - APR_IDX_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ackStrobe_t          strobe,
  input  logic [PRIO_W-1:0]   prioMask,
  input  logic                lrWrEn,
  input  logic [IDX_W-1:0]    lrWrIdx,
  input  logic [ID_W-1:0]     lrWrId,
  input  logic [SRC_W-1:0]    lrWrSrc,
  input  logic [PRIO_W-1:0]   lrWrPrio,
  input  logic                lrWrGroup,
  input  logic [1:0]          lrWrState,
  input  logic                aprWrEn,
  input  logic [APR_W-1:0]    aprWrData,
  output logic                winFound,
  output logic                winGroup1,
  output logic                winQualifies,
  output logic [DATA_W-1:0]   respData,
  output logic [2*NUM_LR-1:0] lrStateOut,
  output logic [APR_W-1:0]    aprOut
);
  logic [ID_W-1:0]   entId    [NUM_LR];
  logic [SRC_W-1:0]  entSrc   [NUM_LR];
  logic [PRIO_W-1:0] entPrio  [NUM_LR];
  logic              entGroup [NUM_LR];
  logic [1:0]        entState [NUM_LR];
  logic [APR_W-1:0]  aprReg;

  logic [IDX_W-1:0]     winIdx;
  logic [PRIO_W-1:0]    winPrio;
  logic                 runValid;
  logic [APR_IDX_W-1:0] runIdx;
  logic [DATA_W-1:0]    fmtData;

  // Highest-priority pending entry; strict compare keeps the lowest index on ties.
  always_comb begin
    winFound = 1'b0;
    winIdx   = '0;
    winPrio  = '1;
    for (int i = 0; i < NUM_LR; i++) begin
      if (entState[i] == LR_PENDING && (!winFound || entPrio[i] < winPrio)) begin
        winFound = 1'b1;
        winIdx   = IDX_W'(i);
        winPrio  = entPrio[i];
      end
    end
  end

  // Running priority: lowest set bit of the active-priority register.
  always_comb begin
    runValid = 1'b0;
    runIdx   = '0;
    for (int i = APR_W - 1; i >= 0; i--) begin
      if (aprReg[i]) begin
        runValid = 1'b1;
        runIdx   = APR_IDX_W'(i);
      end
    end
  end

  assign winGroup1    = entGroup[winIdx];
  assign winQualifies = (winPrio < prioMask) &&
                        (!runValid || winPrio[PRIO_W-1:PRIO_SHIFT] < runIdx);

  always_comb begin
    fmtData = '0;
    fmtData[ID_W-1:0] = entId[winIdx];
    if (entId[winIdx] < ID_W'(SGI_LIMIT))
      fmtData[ID_W+SRC_W-1:ID_W] = entSrc[winIdx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LR; i++) begin
        entId[i]    <= '0;
        entSrc[i]   <= '0;
        entPrio[i]  <= '0;
        entGroup[i] <= 1'b0;
        entState[i] <= LR_INVALID;
      end
    end else begin
      for (int i = 0; i < NUM_LR; i++) begin
        if (lrWrEn && lrWrIdx == IDX_W'(i)) begin
          entId[i]    <= lrWrId;
          entSrc[i]   <= lrWrSrc;
          entPrio[i]  <= lrWrPrio;
          entGroup[i] <= lrWrGroup;
          entState[i] <= lrWrState;
        end else if (strobe.ackFire && winIdx == IDX_W'(i)) begin
          entState[i] <= LR_ACTIVE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aprReg <= '0;
    end else if (aprWrEn) begin
      aprReg <= aprWrData;
    end else if (strobe.ackFire) begin
      aprReg[winPrio[PRIO_W-1:PRIO_SHIFT]] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      respData <= '0;
    end else if (strobe.respLoad) begin
      respData <= strobe.ackFire ? fmtData : DATA_W'(SPURIOUS_ID);
    end
  end

  for (genvar g = 0; g < NUM_LR; g++) begin : gStateOut
    assign lrStateOut[2*g+1:2*g] = entState[g];
  end

  assign aprOut = aprReg;
endmodule

// File: rtl/virq_ack_ctrl.sv
module virq_ack_ctrl
  import virq_ack_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] ACK_OFFSET = 12'h020
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              ctlEnable,
  input  logic              winFound,
  input  logic              winGroup1,
  input  logic              winQualifies,
  output ackStrobe_t        strobe,
  output logic              respValid
);
  logic readHit;

  assign readHit         = reqValid && !reqWrite && (reqAddr == ACK_OFFSET);
  assign strobe.respLoad = readHit;
  assign strobe.ackFire  = readHit && ctlEnable && winFound && winGroup1 && winQualifies;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) respValid <= 1'b0;
    else        respValid <= readHit;
  end
endmodule

// File: rtl/virq_ack_unit.sv
module virq_ack_unit
  import virq_ack_pkg::*;
#(
  parameter int NUM_LR  = 4,
  parameter int ID_W    = 10,
  parameter int SRC_W   = 3,
  parameter int PRIO_W  = 8,
  parameter int APR_W   = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] ACK_OFFSET = 12'h020,
  localparam int IDX_W  = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  output logic                respValid,
  output logic [DATA_W-1:0]   respData,
  input  logic                ctlEnable,
  input  logic [PRIO_W-1:0]   prioMask,
  input  logic                lrWrEn,
  input  logic [IDX_W-1:0]    lrWrIdx,
  input  logic [ID_W-1:0]     lrWrId,
  input  logic [SRC_W-1:0]    lrWrSrc,
  input  logic [PRIO_W-1:0]   lrWrPrio,
  input  logic                lrWrGroup,
  input  logic [1:0]          lrWrState,
  output logic [2*NUM_LR-1:0] lrStateOut,
  input  logic                aprWrEn,
  input  logic [APR_W-1:0]    aprWrData,
  output logic [APR_W-1:0]    aprOut
);
  ackStrobe_t strobe;
  logic winFound, winGroup1, winQualifies;

  virq_ack_ctrl #(.ADDR_W(ADDR_W), .ACK_OFFSET(ACK_OFFSET)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .ctlEnable(ctlEnable), .winFound(winFound),
    .winGroup1(winGroup1), .winQualifies(winQualifies),
    .strobe(strobe), .respValid(respValid)
  );

  virq_ack_datapath #(
    .NUM_LR(NUM_LR), .ID_W(ID_W), .SRC_W(SRC_W), .PRIO_W(PRIO_W),
    .APR_W(APR_W), .DATA_W(DATA_W)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .prioMask(prioMask),
    .lrWrEn(lrWrEn), .lrWrIdx(lrWrIdx), .lrWrId(lrWrId), .lrWrSrc(lrWrSrc),
    .lrWrPrio(lrWrPrio), .lrWrGroup(lrWrGroup), .lrWrState(lrWrState),
    .aprWrEn(aprWrEn), .aprWrData(aprWrData),
    .winFound(winFound), .winGroup1(winGroup1), .winQualifies(winQualifies),
    .respData(respData), .lrStateOut(lrStateOut), .aprOut(aprOut)
  );
endmodule

// File: rtl/virq_ack_checker.sv
module virq_ack_checker
  import virq_ack_pkg::*;
#(
  parameter int NUM_LR = 4,
  parameter int ID_W   = 10,
  parameter int APR_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] ACK_OFFSET = 12'h020
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reqValid,
  input logic                reqWrite,
  input logic [ADDR_W-1:0]   reqAddr,
  input logic                respValid,
  input logic [DATA_W-1:0]   respData,
  input logic                ctlEnable,
  input logic                lrWrEn,
  input logic [2*NUM_LR-1:0] lrStateOut,
  input logic                aprWrEn,
  input logic [APR_W-1:0]    aprOut
);
  localparam logic [DATA_W-1:0] SPUR = DATA_W'(SPURIOUS_ID);

  // R2: a response only follows a read of the acknowledge offset
  assert_resp_follows_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    respValid |-> $past(reqValid && !reqWrite && reqAddr == ACK_OFFSET));

  // R2: upper bits of the response are zero
  assert_resp_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    respValid |-> respData[DATA_W-1:13] == '0);

  // R7: a real acknowledge needs the enable in the request cycle
  assert_ack_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (respValid && respData != SPUR) |-> $past(ctlEnable));

  // R3: a real acknowledge sets exactly one new active-priority bit or keeps it set
  assert_ack_apr_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (respValid && respData != SPUR && !$past(aprWrEn)) |->
      ($countones(aprOut & ~$past(aprOut)) <= 1 && aprOut != '0));

  // R4: a spurious response leaves all state untouched
  assert_spurious_no_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (respValid && respData == SPUR && !$past(lrWrEn) && !$past(aprWrEn)) |->
      (lrStateOut == $past(lrStateOut) && aprOut == $past(aprOut)));

  // R10: bus writes produce no response and no state change
  assert_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqWrite && !lrWrEn && !aprWrEn) |=>
      (!respValid && $stable(lrStateOut) && $stable(aprOut)));

  // R11: without a software load, active-priority bits never clear
  assert_apr_no_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !aprWrEn |=> ((aprOut & $past(aprOut)) == $past(aprOut)));
endmodule

bind virq_ack_unit virq_ack_checker #(
  .NUM_LR(NUM_LR), .ID_W(ID_W), .APR_W(APR_W), .DATA_W(DATA_W),
  .ADDR_W(ADDR_W), .ACK_OFFSET(ACK_OFFSET)
) chk_i (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqAddr(reqAddr), .respValid(respValid), .respData(respData),
  .ctlEnable(ctlEnable), .lrWrEn(lrWrEn), .lrStateOut(lrStateOut),
  .aprWrEn(aprWrEn), .aprOut(aprOut)
);

// File: tb/virq_ack_unit_tb_top.sv
module virq_ack_unit_tb_top;
  localparam int NLR = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [11:0] reqAddr = '0;
  logic        respValid;
  logic [31:0] respData;
  logic        ctlEnable = 1'b0;
  logic [7:0]  prioMask = 8'hFF;
  logic        lrWrEn = 1'b0;
  logic [1:0]  lrWrIdx = '0;
  logic [9:0]  lrWrId = '0;
  logic [2:0]  lrWrSrc = '0;
  logic [7:0]  lrWrPrio = '0;
  logic        lrWrGroup = 1'b0;
  logic [1:0]  lrWrState = '0;
  logic [7:0]  lrStateOut;
  logic        aprWrEn = 1'b0;
  logic [31:0] aprWrData = '0;
  logic [31:0] aprOut;

  always #2 clk = ~clk;

  virq_ack_unit dut_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .respValid(respValid), .respData(respData),
    .ctlEnable(ctlEnable), .prioMask(prioMask), .lrWrEn(lrWrEn),
    .lrWrIdx(lrWrIdx), .lrWrId(lrWrId), .lrWrSrc(lrWrSrc),
    .lrWrPrio(lrWrPrio), .lrWrGroup(lrWrGroup), .lrWrState(lrWrState),
    .lrStateOut(lrStateOut), .aprWrEn(aprWrEn), .aprWrData(aprWrData),
    .aprOut(aprOut)
  );

  int checks = 0;
  int failures = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  // Bench model of the list and active-priority register
  logic [9:0] mId[NLR];
  logic [2:0] mSrc[NLR];
  logic [7:0] mPrio[NLR];
  logic       mGrp[NLR];
  logic [1:0] mState[NLR];
  logic [31:0] mApr = '0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected responses as they appear
  always @(negedge clk) begin
    if (rst_n && respValid) begin
      if (expQ.size() == 0) begin
        check("R10 unexpected response", 32'h1, 32'h0);
      end else begin
        check(tagQ.pop_front(), respData, expQ.pop_front());
      end
    end
  end

  task automatic setEntry(input int idx, input logic [9:0] id, input logic [2:0] src,
                          input logic [7:0] prio, input logic grp, input logic [1:0] st);
    @(negedge clk);
    lrWrEn = 1'b1; lrWrIdx = 2'(idx); lrWrId = id; lrWrSrc = src;
    lrWrPrio = prio; lrWrGroup = grp; lrWrState = st;
    mId[idx] = id; mSrc[idx] = src; mPrio[idx] = prio; mGrp[idx] = grp; mState[idx] = st;
    @(negedge clk);
    lrWrEn = 1'b0;
  endtask

  task automatic setApr(input logic [31:0] v);
    @(negedge clk);
    aprWrEn = 1'b1; aprWrData = v; mApr = v;
    @(negedge clk);
    aprWrEn = 1'b0;
  endtask

  task automatic clearAll();
    for (int i = 0; i < NLR; i++) setEntry(i, 10'd0, 3'd0, 8'd0, 1'b0, 2'b00);
    setApr('0);
  endtask

  // Driver: compute expected result from the requirements, push, then issue the read
  task automatic doRead(input string tag);
    int  w;
    int  run;
    logic [31:0] exp;
    w = -1;
    for (int i = 0; i < NLR; i++)
      if (mState[i] == 2'b01 && (w < 0 || mPrio[i] < mPrio[w])) w = i;
    run = 32;
    for (int i = 31; i >= 0; i--) if (mApr[i]) run = i;
    exp = 32'd1023;
    if (ctlEnable && w >= 0 && mGrp[w] && mPrio[w] < prioMask && int'(mPrio[w][7:3]) < run) begin
      exp = {22'd0, mId[w]};
      if (mId[w] < 10'd16) exp[12:10] = mSrc[w];
      mState[w] = 2'b10;
      mApr[mPrio[w][7:3]] = 1'b1;
    end
    @(negedge clk);
    expQ.push_back(exp); tagQ.push_back(tag);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 12'h020;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic checkState(input string tag);
    logic [7:0] st;
    for (int i = 0; i < NLR; i++) st[2*i +: 2] = mState[i];
    check({tag, " states"}, {24'd0, lrStateOut}, {24'd0, st});
    check({tag, " apr"}, aprOut, mApr);
  endtask

  task automatic busPulse(input logic wr, input logic [11:0] addr);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < NLR; i++) begin
      mId[i] = '0; mSrc[i] = '0; mPrio[i] = '0; mGrp[i] = 1'b0; mState[i] = 2'b00;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 respValid", {31'd0, respValid}, 32'd0);
    check("R1 apr", aprOut, 32'd0);
    check("R1 states", {24'd0, lrStateOut}, 32'd0);
    rst_n = 1'b1;
    ctlEnable = 1'b1; prioMask = 8'hFF;

    // R8: nothing pending
    doRead("R8 no pending");
    // R3: single Group 1 acknowledge
    setEntry(0, 10'd35, 3'd5, 8'h40, 1'b1, 2'b01);
    doRead("R3 ack group1");
    checkState("R3");
    // R4: Group 0 winner blocks a lower-priority Group 1 entry
    clearAll();
    setEntry(1, 10'd60, 3'd0, 8'h10, 1'b0, 2'b01);
    setEntry(2, 10'd61, 3'd0, 8'h20, 1'b1, 2'b01);
    doRead("R4 group0 winner");
    checkState("R4");
    // R7: disabled
    clearAll();
    setEntry(0, 10'd70, 3'd0, 8'h08, 1'b1, 2'b01);
    ctlEnable = 1'b0;
    doRead("R7 disabled");
    checkState("R7");
    ctlEnable = 1'b1;
    // R5: mask is strict
    setEntry(0, 10'd71, 3'd0, 8'h80, 1'b1, 2'b01);
    prioMask = 8'h80;
    doRead("R5 mask equal");
    prioMask = 8'h81;
    doRead("R5 mask above");
    checkState("R5");
    prioMask = 8'hFF;
    // R6: running priority is strict
    clearAll();
    setApr(32'h0000_0010);
    setEntry(0, 10'd80, 3'd0, 8'h20, 1'b1, 2'b01);
    doRead("R6 equal running");
    setEntry(1, 10'd81, 3'd0, 8'h18, 1'b1, 2'b01);
    doRead("R6 above running");
    checkState("R6");
    // R9: tie broken by lower index
    clearAll();
    setEntry(3, 10'd93, 3'd0, 8'h30, 1'b1, 2'b01);
    setEntry(1, 10'd91, 3'd0, 8'h30, 1'b1, 2'b01);
    doRead("R9 tie first");
    doRead("R9 tie second");
    checkState("R9");
    // R2: source CPU field for low IDs only
    clearAll();
    setEntry(2, 10'd5, 3'd6, 8'h50, 1'b1, 2'b01);
    doRead("R2 sgi source");
    setEntry(2, 10'd40, 3'd6, 8'h50, 1'b1, 2'b01);
    doRead("R2 non-sgi");
    // R10: write ignored, other offset no response
    setEntry(0, 10'd100, 3'd0, 8'h08, 1'b1, 2'b01);
    busPulse(1'b1, 12'h020);
    checkState("R10 write");
    busPulse(1'b0, 12'h024);
    checkState("R10 other offset");
    // R11: APR write port overrides
    setApr(32'hA5A5_0000);
    checkState("R11 apr load");
    doRead("R11 after load");
    checkState("R11 after ack");

    repeat (4) @(negedge clk);
    check("R2 queue drained", 32'(expQ.size()), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule